// File: doc/BRIEF.md
# Offset-Partitioned Branch Target Buffer

This block predicts branch targets for a fetch-directed instruction prefetcher. It keeps one entry per branch instruction and never a basic-block size. Its storage is split into four set-associative tables. Three tables hold signed PC-relative offsets of 8, 13 and 23 bits. The fourth holds a full 48-bit target for branches whose displacement fits none of the offset widths. Short branches therefore use narrow entries, so more branches fit in the same storage.

A lookup presents a fetch PC. All four tables are probed in the same cycle and the registered result appears one cycle later. The result carries the hit flag, the rebuilt target and the branch type. An update presents a resolved branch. The block computes the displacement (target minus PC) and installs the branch in the narrowest table that can represent that displacement. It removes any copy of the same branch from the other three tables.

Every table uses PC bits [9:2] as a 256-set index. Each table stores a 16-bit tag formed by XOR-folding the PC bits above the index. Each set has four ways and a three-bit tree pseudo-LRU that is touched on lookup hits and on installs.

Top module: `obtb_top`

## Requirements
- R1: While reset is high and in the cycle after reset, `rsp_valid` and `rsp_hit` are 0, and every entry is invalid, so the first lookup after reset misses.
- R2: A lookup request asserted before a rising edge gives `rsp_valid` = 1 right after that edge, and `rsp_valid` is 0 after an edge with no request.
- R3: A branch whose displacement lies in [-128, 127] hits and returns PC plus displacement.
- R4: A branch whose displacement lies in [-4096, 4095] but outside R3's range hits and returns PC plus displacement.
- R5: A branch whose displacement lies in [-2^22, 2^22-1] but outside R4's range hits and returns PC plus displacement.
- R6: A branch whose displacement lies outside R5's range hits and returns the installed 48-bit target unchanged.
- R7: `rsp_type` returns the type given at install: 0 conditional, 1 unconditional, 2 call, 3 return.
- R8: Re-installing a branch moves it to the table chosen by its new displacement and invalidates its old copy, so only the newest target is returned.
- R9: Each table holds four branches per set. A fifth install in the same set and table replaces the tree pseudo-LRU victim. Tree bit 0 picks the half (0 = ways 0-1), bit 1 picks within ways 0-1 and bit 2 picks within ways 2-3 (0 = lower way), and each access points the bits away from the accessed way. Installs in other tables do not evict it.
- R10: The tag is the XOR fold of PC[47:10], with PC bit 10+i feeding tag bit i mod 16. Two PCs that differ only in bits 10 and 26 share an entry, while a PC that differs only in bit 10 misses.
- R11: When a lookup misses, `rsp_hit` is 0 while `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 48 | Fetch PC to look up |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_hit | output | 1 | Branch found |
| rsp_target | output | 48 | Predicted target |
| rsp_type | output | 2 | Branch type |
| upd_en | input | 1 | Install or refresh a resolved branch |
| upd_pc | input | 48 | Resolved branch PC |
| upd_target | input | 48 | Resolved branch target |
| upd_type | input | 2 | Resolved branch type |

## Verification
A lookup result is due exactly one rising edge after the request. An install is visible to any lookup whose request is presented after the install's edge. The bench drives each request on a falling edge and pushes the expected result into a scoreboard queue at that moment. A monitor samples on the following falling edge whenever `rsp_valid` is high, pops the queue and compares. Any response without a queued expectation counts as a failure, and so does any expectation still unserved at the end. Replacement is checked by building a known tree state through a fixed sequence of installs and one lookup, then probing each branch of that set.

// File: rtl/obtb_pkg.sv
package obtb_pkg;

    typedef enum logic [1:0] {
        BR_COND = 2'd0,
        BR_JUMP = 2'd1,
        BR_CALL = 2'd2,
        BR_RET  = 2'd3
    } btype_e;

    // tree bits: [0] half select, [1] left pair, [2] right pair
    function automatic logic [1:0] plru_victim(input logic [2:0] t);
        if (!t[0]) return t[1] ? 2'd1 : 2'd0;
        return t[2] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] n;
        n = t;
        if (!w[1]) begin
            n[0] = 1'b1;
            n[1] = (w == 2'd0);
        end else begin
            n[0] = 1'b0;
            n[2] = (w == 2'd2);
        end
        return n;
    endfunction

    function automatic logic [1:0] first_one(input logic [3:0] v);
        for (int i = 0; i < 4; i++)
            if (v[i]) return 2'(i);
        return 2'd0;
    endfunction

endpackage

// File: rtl/obtb_table.sv
module obtb_table
    import obtb_pkg::*;
#(
    parameter int OFF_W = 8,
    parameter int SETS  = 256,
    parameter int TAG_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       lk_req,
    input  logic [$clog2(SETS)-1:0]    lk_idx,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic                       lk_hit,
    output logic [OFF_W-1:0]           lk_off,
    output btype_e                     lk_type,
    input  logic                       wr_install,
    input  logic                       wr_inval,
    input  logic [$clog2(SETS)-1:0]    wr_idx,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [OFF_W-1:0]           wr_off,
    input  btype_e                     wr_type
);
    localparam int WAYS = 4;

    logic               vld   [SETS][WAYS];
    logic [TAG_W-1:0]   tag_m [SETS][WAYS];
    logic [OFF_W-1:0]   off_m [SETS][WAYS];
    btype_e             typ_m [SETS][WAYS];
    logic [2:0]         tree  [SETS];

    logic [WAYS-1:0] lk_match, wr_match, wr_free;
    logic [1:0]      lk_way, wr_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_match[w] = vld[lk_idx][w] && (tag_m[lk_idx][w] == lk_tag);
        assign wr_match[w] = vld[wr_idx][w] && (tag_m[wr_idx][w] == wr_tag);
        assign wr_free[w]  = !vld[wr_idx][w];
    end

    assign lk_way  = first_one(lk_match);
    assign lk_hit  = |lk_match;
    assign lk_off  = off_m[lk_idx][lk_way];
    assign lk_type = typ_m[lk_idx][lk_way];

    always_comb begin
        if (|wr_match)     wr_way = first_one(wr_match);
        else if (|wr_free) wr_way = first_one(wr_free);
        else               wr_way = plru_victim(tree[wr_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tree[s] <= 3'b000;
                for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
            end
        end else begin
            if (lk_req && lk_hit)
                tree[lk_idx] <= plru_touch(tree[lk_idx], lk_way);
            if (wr_install) begin
                vld[wr_idx][wr_way]   <= 1'b1;
                tag_m[wr_idx][wr_way] <= wr_tag;
                off_m[wr_idx][wr_way] <= wr_off;
                typ_m[wr_idx][wr_way] <= wr_type;
                tree[wr_idx]          <= plru_touch(tree[wr_idx], wr_way);
            end else if (wr_inval && |wr_match) begin
                vld[wr_idx][first_one(wr_match)] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/obtb_top.sv
module obtb_top
    import obtb_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFF0_W = 8,
    parameter int OFF1_W = 13,
    parameter int OFF2_W = 23,
    parameter int SETS   = 256,
    parameter int TAG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_target,
    output logic [1:0]        rsp_type,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic [1:0]        upd_type
);
    localparam int NTAB  = 4;
    localparam int IDX_W = $clog2(SETS);
    localparam int LO    = IDX_W + 2;
    localparam int HI_W  = ADDR_W - LO;

    function automatic logic [TAG_W-1:0] fold_tag(input logic [ADDR_W-1:0] pc);
        logic [TAG_W-1:0] t;
        t = '0;
        for (int i = 0; i < HI_W; i++) t[i % TAG_W] ^= pc[LO + i];
        return t;
    endfunction

    logic [IDX_W-1:0]  lk_idx, wr_idx;
    logic [TAG_W-1:0]  lk_tag, wr_tag;
    logic [ADDR_W-1:0] disp;
    logic [NTAB-1:0]   fits, tbl_hit;
    logic [1:0]        sel;
    logic [ADDR_W-1:0] tbl_tgt [NTAB];
    btype_e            tbl_typ [NTAB];

    assign lk_idx = lk_pc[LO-1:2];
    assign wr_idx = upd_pc[LO-1:2];
    assign lk_tag = fold_tag(lk_pc);
    assign wr_tag = fold_tag(upd_pc);
    assign disp   = upd_target - upd_pc;

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        localparam int W = (t == 0) ? OFF0_W : (t == 1) ? OFF1_W :
                           (t == 2) ? OFF2_W : ADDR_W;
        logic [W-1:0] rd_off, wr_off;
        logic         t_hit;
        btype_e       t_typ;

        if (t == NTAB - 1) begin : g_full
            assign fits[t]    = 1'b1;
            assign wr_off     = upd_target;
            assign tbl_tgt[t] = rd_off;
        end else begin : g_rel
            logic [ADDR_W-1:0] upper;
            assign upper      = ADDR_W'($signed(disp) >>> (W - 1));
            assign fits[t]    = (upper == '0) || (upper == '1);
            assign wr_off     = disp[W-1:0];
            assign tbl_tgt[t] = lk_pc + {{(ADDR_W-W){rd_off[W-1]}}, rd_off};
        end

        obtb_table #(.OFF_W(W), .SETS(SETS), .TAG_W(TAG_W)) u_tab (
            .clk        (clk),
            .rst        (rst),
            .lk_req     (lk_req),
            .lk_idx     (lk_idx),
            .lk_tag     (lk_tag),
            .lk_hit     (t_hit),
            .lk_off     (rd_off),
            .lk_type    (t_typ),
            .wr_install (upd_en && (sel == 2'(t))),
            .wr_inval   (upd_en && (sel != 2'(t))),
            .wr_idx     (wr_idx),
            .wr_tag     (wr_tag),
            .wr_off     (wr_off),
            .wr_type    (btype_e'(upd_type))
        );
        assign tbl_hit[t] = t_hit;
        assign tbl_typ[t] = t_typ;
    end

    // narrowest fitting table wins
    always_comb begin
        sel = 2'(NTAB - 1);
        for (int t = NTAB - 2; t >= 0; t--)
            if (fits[t]) sel = 2'(t);
    end

    // full table first, then wider offsets before narrower ones
    logic              pick_hit;
    logic [ADDR_W-1:0] pick_tgt;
    btype_e            pick_typ;
    always_comb begin
        pick_hit = 1'b0;
        pick_tgt = '0;
        pick_typ = BR_COND;
        for (int t = 0; t < NTAB; t++) begin
            if (tbl_hit[t]) begin
                pick_hit = 1'b1;
                pick_tgt = tbl_tgt[t];
                pick_typ = tbl_typ[t];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_target <= '0;
            rsp_type   <= 2'd0;
        end else begin
            rsp_valid  <= lk_req;
            rsp_hit    <= lk_req && pick_hit;
            rsp_target <= pick_tgt;
            rsp_type   <= pick_typ;
        end
    end

endmodule

// File: rtl/obtb_checker.sv
module obtb_checker (
    input logic       clk,
    input logic       rst,
    input logic       lk_req,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic [3:0] tbl_hit
);
    // R1: reset leaves the response quiet
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!rsp_valid && !rsp_hit));

    // R2: response valid follows a request by one edge
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst) lk_req |=> rsp_valid);

    // R2: no response without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !rsp_valid);

    // R8: a branch lives in at most one table
    a_r8_single_table: assert property (@(posedge clk) disable iff (rst) lk_req |-> $onehot0(tbl_hit));

    // R11: a hit is only reported on a valid response
    a_r11_hit_in_valid: assert property (@(posedge clk) disable iff (rst) rsp_hit |-> rsp_valid);
endmodule

bind obtb_top obtb_checker u_obtb_checker (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .tbl_hit   (tbl_hit)
);

// File: tb/obtb_top_bench.sv
module obtb_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [47:0] lk_pc = '0;
    logic        rsp_valid, rsp_hit;
    logic [47:0] rsp_target;
    logic [1:0]  rsp_type;
    logic        upd_en = 1'b0;
    logic [47:0] upd_pc = '0, upd_target = '0;
    logic [1:0]  upd_type = '0;

    int total = 0;
    int bad   = 0;

    bit          q_hit [$];
    logic [47:0] q_tgt [$];
    logic [1:0]  q_typ [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    obtb_top u_obtb_top (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_pc(lk_pc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
        .rsp_type(rsp_type), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_type(upd_type)
    );

    function automatic logic [47:0] mkpc(input int set, input logic [37:0] hi);
        return {hi, set[7:0], 2'b00};
    endfunction

    task automatic upd(input logic [47:0] pc, input logic [47:0] tgt, input logic [1:0] ty);
        @(negedge clk);
        upd_en = 1'b1; upd_pc = pc; upd_target = tgt; upd_type = ty;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic look(input logic [47:0] pc, input bit eh, input logic [47:0] et,
                        input logic [1:0] ety, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_pc = pc;
        q_hit.push_back(eh); q_tgt.push_back(et); q_typ.push_back(ety); q_tag.push_back(tag);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            total++;
            if (q_hit.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected response: actual=valid expected=none");
            end else begin
                automatic bit          eh  = q_hit.pop_front();
                automatic logic [47:0] et  = q_tgt.pop_front();
                automatic logic [1:0]  ety = q_typ.pop_front();
                automatic string       tg  = q_tag.pop_front();
                if (rsp_hit !== eh) begin
                    bad++;
                    $display("FAIL %s hit: actual=%0b expected=%0b", tg, rsp_hit, eh);
                end else if (eh && (rsp_target !== et || rsp_type !== ety)) begin
                    bad++;
                    $display("FAIL %s target/type: actual=%h/%0d expected=%h/%0d",
                             tg, rsp_target, rsp_type, et, ety);
                end
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [47:0] p, a, b;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        total++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            bad++; $display("FAIL R1 reset outputs: actual=%b%b expected=00", rsp_valid, rsp_hit);
        end
        rst = 1'b0;
        // R1 / R11: empty buffer misses
        look(mkpc(5, 38'h1), 1'b0, '0, 2'd0, "R1");
        look(mkpc(6, 38'h7), 1'b0, '0, 2'd0, "R11");
        // R2: idle cycle gives no response
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++; $display("FAIL R2 idle valid: actual=%b expected=0", rsp_valid);
        end

        // R3: 8-bit range edges
        p = mkpc(10, 38'h1); upd(p, p + 48'd127, 2'd0); look(p, 1'b1, p + 48'd127, 2'd0, "R3");
        p = mkpc(11, 38'h1); upd(p, p - 48'd128, 2'd1); look(p, 1'b1, p - 48'd128, 2'd1, "R3");
        // R4: 13-bit range
        p = mkpc(12, 38'h1); upd(p, p + 48'd128, 2'd2);  look(p, 1'b1, p + 48'd128, 2'd2, "R4");
        p = mkpc(13, 38'h1); upd(p, p - 48'd4096, 2'd0); look(p, 1'b1, p - 48'd4096, 2'd0, "R4");
        p = mkpc(14, 38'h1); upd(p, p + 48'd4095, 2'd1); look(p, 1'b1, p + 48'd4095, 2'd1, "R4");
        // R5: 23-bit range
        p = mkpc(15, 38'h1); upd(p, p + 48'd4096, 2'd0);      look(p, 1'b1, p + 48'd4096, 2'd0, "R5");
        p = mkpc(16, 38'h1); upd(p, p - 48'h40_0000, 2'd2);   look(p, 1'b1, p - 48'h40_0000, 2'd2, "R5");
        p = mkpc(17, 38'h1); upd(p, p + 48'h3F_FFFF, 2'd1);   look(p, 1'b1, p + 48'h3F_FFFF, 2'd1, "R5");
        // R6: full-address table
        p = mkpc(18, 38'h1); upd(p, p + 48'h40_0000, 2'd1);   look(p, 1'b1, p + 48'h40_0000, 2'd1, "R6");
        p = mkpc(19, 38'h1); upd(p, 48'hFFFF_0000_1234, 2'd2); look(p, 1'b1, 48'hFFFF_0000_1234, 2'd2, "R6");
        // R7: return type
        p = mkpc(20, 38'h2); upd(p, p + 48'd40, 2'd3); look(p, 1'b1, p + 48'd40, 2'd3, "R7");

        // R8: move between tables, stale copy removed
        p = mkpc(21, 38'h3);
        upd(p, p + 48'd4, 2'd0);          look(p, 1'b1, p + 48'd4, 2'd0, "R8");
        upd(p, p + 48'h4000_0000, 2'd1);  look(p, 1'b1, p + 48'h4000_0000, 2'd1, "R8");
        upd(p, p + 48'd16, 2'd2);         look(p, 1'b1, p + 48'd16, 2'd2, "R8");

        // R9: replacement in one set of the 8-bit table
        for (int h = 1; h <= 4; h++) begin
            p = mkpc(30, 38'(h)); upd(p, p + 48'd8, 2'd0);
        end
        look(mkpc(30, 38'h1), 1'b1, mkpc(30, 38'h1) + 48'd8, 2'd0, "R9");
        p = mkpc(30, 38'h5); upd(p, p + 48'd8, 2'd0);
        p = mkpc(30, 38'h6); upd(p, p + 48'h1_0000_0000, 2'd1);
        look(mkpc(30, 38'h1), 1'b1, mkpc(30, 38'h1) + 48'd8, 2'd0, "R9");
        look(mkpc(30, 38'h2), 1'b1, mkpc(30, 38'h2) + 48'd8, 2'd0, "R9");
        look(mkpc(30, 38'h3), 1'b0, '0, 2'd0, "R9");
        look(mkpc(30, 38'h4), 1'b1, mkpc(30, 38'h4) + 48'd8, 2'd0, "R9");
        look(mkpc(30, 38'h5), 1'b1, mkpc(30, 38'h5) + 48'd8, 2'd0, "R9");
        look(mkpc(30, 38'h6), 1'b1, mkpc(30, 38'h6) + 48'h1_0000_0000, 2'd1, "R9");

        // R10: tag folding alias
        a = mkpc(40, 38'h5);
        b = a ^ (48'd1 << 10) ^ (48'd1 << 26);
        upd(a, a + 48'd20, 2'd1);
        look(b, 1'b1, b + 48'd20, 2'd1, "R10");
        look(a ^ (48'd1 << 10), 1'b0, '0, 2'd0, "R10");

        repeat (3) @(negedge clk);
        total++;
        if (q_hit.size() != 0) begin
            bad++; $display("FAIL R2 missing responses: actual=%0d expected=0", q_hit.size());
        end
        finish_run();
    end
endmodule